// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block gathers the interrupt events of an audio controller into one read-only status byte, gates that byte with a software-written enable mask, and drives a single interrupt request line. Five event sources arrive as one-cycle pulses and each latches a sticky flag:

- converter unlock
- converter lock
- ramp-up complete
- ramp-down complete
- mute complete

Two further flags summarise a channel-overflow source and a GPIO source. Both of these sources are presented as levels.

Software reaches the block over a plain register port with an address, a read strobe, a write strobe, write data and combinational read data. Reading the status byte clears the five event flags and leaves the two summary flags alone. Each summary flag has its own clear: a read of the channel-overflow sub-status address, or a read of the GPIO sub-status address. Each summary flag works in edge or level mode. A lock event cancels a pending unlock flag, so the status always reports the most recent converter state. The register port carries no stream, so it has no valid/ready handshake and no back-pressure: a strobe is acted on in the cycle it is high.

Top module: `irq_status_hub`

## Requirements
- R1: After reset the mask byte at address 29h reads 00h, the status byte at address 2Ah reads 00h, and irq is low.
- R2: The event pulses set status bits whether or not they are masked. The bit positions are: unlock = bit 7, lock = bit 6, ramp-up = bit 5, ramp-down = bit 4, mute = bit 3. Status bit 0 always reads 0.
- R3: A read of address 2Ah clears status bits 7 to 3 at the clock edge that ends the read. It leaves bit 2 (overflow summary) and bit 1 (GPIO summary) unchanged.
- R4: If an event pulse arrives in the same cycle as a clearing read, its status bit is set after that cycle.
- R5: A lock pulse with no unlock pulse in the same cycle clears status bit 7.
- R6: A write to 29h stores data bits 7 to 2 into the mask, and mask bits 1 and 0 read as 0. Writes to 2Ah have no effect. Reads of any address other than 29h and 2Ah return 00h.
- R7: irq is the OR over bits 7 to 2 of (status AND mask), ORed with status bit 1 regardless of the mask.
- R8: With ovf_edge_sel = 1, a rising edge of ovf_src sets status bit 2. Only a read of address 2Bh clears it, even while ovf_src stays high.
- R9: With ovf_edge_sel = 0, status bit 2 is set while ovf_src is high, and a read of 2Bh does not clear it then. Once ovf_src is low, a read of 2Bh clears it.
- R10: Status bit 1 follows gpio_src and gpio_edge_sel with the same edge and level rules, cleared by a read of address 2Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears take effect at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ev_unlock | input | 1 | Converter unlock event pulse |
| ev_lock | input | 1 | Converter lock event pulse |
| ev_rampup | input | 1 | Ramp-up complete pulse |
| ev_rampdn | input | 1 | Ramp-down complete pulse |
| ev_mute | input | 1 | Mute complete pulse |
| ovf_src | input | 1 | Channel-overflow source level |
| ovf_edge_sel | input | 1 | Overflow mode: 1 = edge, 0 = level |
| gpio_src | input | 1 | GPIO source level |
| gpio_edge_sel | input | 1 | GPIO mode: 1 = edge, 0 = level |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things:

- each event flag rises after its pulse and drops after a clearing read;
- a lock cancels a pending unlock;
- a level-mode summary flag cannot drop while its source is high;
- writes to the status address leave it unchanged, and an all-zero mask with no GPIO flag keeps irq low.

Only the bench scenarios show the following:

- the byte-level bit positions of each flag;
- the different clearing rules of the three read addresses;
- an edge-mode flag staying cleared while its source is still high;
- a summary flag clearing only after the level falls and a later sub-status read.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] MASK_ADDR = 8'h29;
  localparam logic [AW-1:0] STAT_ADDR = 8'h2A;
  localparam logic [AW-1:0] OVF_ADDR  = 8'h2B;
  localparam logic [AW-1:0] GPIO_ADDR = 8'h2F;
  localparam int NUM_EDGE = 5;
  localparam int EDGE_LSB = 3;
  localparam int OVF_BIT  = 2;
  localparam int GPIO_BIT = 1;
  localparam int UNLOCK_IDX = NUM_EDGE - 1;
endpackage

// File: rtl/sticky_event_flag.sv
module sticky_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic cancel_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q_o <= 1'b0;
    else if (set_i)            q_o <= 1'b1;
    else if (clr_i || cancel_i) q_o <= 1'b0;
  end

  // R2
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R3
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i || cancel_i) && !set_i) |=> !q_o);
endmodule

// File: rtl/summary_flag.sv
module summary_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic q_o
);
  logic src_d;
  logic hit;

  always_comb hit = edge_mode_i ? (src_i && !src_d) : src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d <= 1'b0;
      q_o   <= 1'b0;
    end else begin
      src_d <= src_i;
      q_o   <= hit || (q_o && !clr_i);
    end
  end

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode_i && src_i) |=> q_o);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter logic [AW-1:0] P_MASK_ADDR = MASK_ADDR,
  parameter logic [AW-1:0] P_STAT_ADDR = STAT_ADDR,
  parameter logic [AW-1:0] P_OVF_ADDR  = OVF_ADDR,
  parameter logic [AW-1:0] P_GPIO_ADDR = GPIO_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_unlock,
  input  logic          ev_lock,
  input  logic          ev_rampup,
  input  logic          ev_rampdn,
  input  logic          ev_mute,
  input  logic          ovf_src,
  input  logic          ovf_edge_sel,
  input  logic          gpio_src,
  input  logic          gpio_edge_sel,
  output logic          irq
);
  localparam logic [DW-1:0] MASK_KEEP = {{(DW-OVF_BIT){1'b1}}, {OVF_BIT{1'b0}}};

  logic [NUM_EDGE-1:0] ev_bus;
  logic [NUM_EDGE-1:0] edge_q;
  logic [DW-1:0]       mask_q;
  logic [DW-1:0]       status;
  logic                ovf_q, gpio_q;
  logic                rd_stat, rd_ovf, rd_gpio, wr_mask;

  always_comb begin
    ev_bus  = {ev_unlock, ev_lock, ev_rampup, ev_rampdn, ev_mute};
    rd_stat = reg_rd && (reg_addr == P_STAT_ADDR);
    rd_ovf  = reg_rd && (reg_addr == P_OVF_ADDR);
    rd_gpio = reg_rd && (reg_addr == P_GPIO_ADDR);
    wr_mask = reg_wr && (reg_addr == P_MASK_ADDR);
  end

  for (genvar i = 0; i < NUM_EDGE; i++) begin : g_evt
    logic cancel;
    if (i == UNLOCK_IDX) begin : g_unlock
      always_comb cancel = ev_lock;
    end else begin : g_plain
      always_comb cancel = 1'b0;
    end
    sticky_event_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev_bus[i]),
      .clr_i   (rd_stat),
      .cancel_i(cancel),
      .q_o     (edge_q[i])
    );
  end

  summary_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .src_i(ovf_src), .edge_mode_i(ovf_edge_sel),
    .clr_i(rd_ovf), .q_o(ovf_q)
  );

  summary_flag u_gpio (
    .clk(clk), .rst_n(rst_n), .src_i(gpio_src), .edge_mode_i(gpio_edge_sel),
    .clr_i(rd_gpio), .q_o(gpio_q)
  );

  always_comb status = {edge_q, ovf_q, gpio_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata & MASK_KEEP;
  end

  always_comb begin
    if (reg_addr == P_MASK_ADDR)      reg_rdata = mask_q;
    else if (reg_addr == P_STAT_ADDR) reg_rdata = status;
    else                              reg_rdata = '0;
  end

  always_comb irq = (|(status[DW-1:OVF_BIT] & mask_q[DW-1:OVF_BIT])) || status[GPIO_BIT];

  // R5
  lock_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lock && !ev_unlock) |=> !status[DW-1]);
  // R6
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == P_STAT_ADDR && !reg_rd && !ev_lock && !(|ev_bus)
     && !ovf_src && !gpio_src) |=> $stable(status));
  // R6
  mask_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == P_MASK_ADDR) |-> (reg_rdata[OVF_BIT-1:0] == '0));
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && !status[GPIO_BIT]) |-> !irq);
endmodule

// File: tb/tb_irq_status_hub.sv
module tb_irq_status_hub;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic ev_unlock = 0, ev_lock = 0, ev_rampup = 0, ev_rampdn = 0, ev_mute = 0;
  logic ovf_src = 0, ovf_edge_sel = 0, gpio_src = 0, gpio_edge_sel = 0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_status_hub dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_unlock(ev_unlock),
    .ev_lock(ev_lock), .ev_rampup(ev_rampup), .ev_rampdn(ev_rampdn), .ev_mute(ev_mute),
    .ovf_src(ovf_src), .ovf_edge_sel(ovf_edge_sel), .gpio_src(gpio_src),
    .gpio_edge_sel(gpio_edge_sel), .irq(irq)
  );

  // ev = {unlock, lock, rampup, rampdn, mute}
  task automatic set_ev(input logic [4:0] ev);
    {ev_unlock, ev_lock, ev_rampup, ev_rampdn, ev_mute} = ev;
  endtask

  task automatic pulse(input logic [4:0] ev);
    @(negedge clk); set_ev(ev);
    @(negedge clk); set_ev(5'b0);
  endtask

  task automatic rd_chk(input logic [7:0] addr, input logic [7:0] exp,
                        input string tag, input logic [4:0] ev = 5'b0);
    @(negedge clk);
    reg_addr = addr; reg_rd = 1'b1; set_ev(ev);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0; set_ev(5'b0);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    reg_addr = addr; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk); #1;
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  // monitor: pops expected read data
  always begin
    @(negedge clk); #1;
    if (reg_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s rdata @%02h: actual %02h expected %02h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    irq_chk(1'b0, "R1");
    rd_chk(8'h29, 8'h00, "R1");
    rd_chk(8'h2A, 8'h00, "R1");
    // R2 capture while masked, R3 clear on read
    pulse(5'b00111);
    irq_chk(1'b0, "R7 masked");
    rd_chk(8'h2A, 8'h38, "R2");
    rd_chk(8'h2A, 8'h00, "R3");
    // R6 mask write, reserved bits, status write ignored, other address
    wr(8'h29, 8'hFF);
    rd_chk(8'h29, 8'hFC, "R6");
    wr(8'h2A, 8'hFF);
    rd_chk(8'h2A, 8'h00, "R6");
    rd_chk(8'h30, 8'h00, "R6");
    // R7 masked path
    pulse(5'b00001);
    irq_chk(1'b1, "R7");
    rd_chk(8'h2A, 8'h08, "R2");
    irq_chk(1'b0, "R7");
    // R4 event during clearing read
    rd_chk(8'h2A, 8'h00, "R4", 5'b00100);
    rd_chk(8'h2A, 8'h20, "R4");
    // R5 lock cancels unlock
    pulse(5'b10000);
    rd_chk(8'h2A, 8'h80, "R2");
    pulse(5'b10000);
    pulse(5'b01000);
    rd_chk(8'h2A, 8'h40, "R5");
    // R8 overflow edge mode
    wr(8'h29, 8'h04);
    @(negedge clk); ovf_edge_sel = 1'b1; ovf_src = 1'b1;
    irq_chk(1'b1, "R8");
    rd_chk(8'h2A, 8'h04, "R8");
    rd_chk(8'h2A, 8'h04, "R3");
    rd_chk(8'h2B, 8'h00, "R8");
    rd_chk(8'h2A, 8'h00, "R8");
    irq_chk(1'b0, "R8");
    @(negedge clk); ovf_src = 1'b0;
    // R9 overflow level mode
    @(negedge clk); ovf_edge_sel = 1'b0; ovf_src = 1'b1;
    rd_chk(8'h2A, 8'h04, "R9");
    rd_chk(8'h2B, 8'h00, "R9");
    rd_chk(8'h2A, 8'h04, "R9");
    @(negedge clk); ovf_src = 1'b0;
    rd_chk(8'h2A, 8'h04, "R9");
    rd_chk(8'h2B, 8'h00, "R9");
    rd_chk(8'h2A, 8'h00, "R9");
    // R10 GPIO edge mode, unmasked irq
    wr(8'h29, 8'h00);
    @(negedge clk); gpio_edge_sel = 1'b1; gpio_src = 1'b1;
    @(negedge clk); gpio_src = 1'b0;
    irq_chk(1'b1, "R7 gpio");
    rd_chk(8'h2B, 8'h00, "R10");
    rd_chk(8'h2A, 8'h02, "R10");
    rd_chk(8'h2F, 8'h00, "R10");
    rd_chk(8'h2A, 8'h00, "R10");
    // R10 GPIO level mode
    @(negedge clk); gpio_edge_sel = 1'b0; gpio_src = 1'b1;
    rd_chk(8'h2F, 8'h00, "R10");
    rd_chk(8'h2A, 8'h02, "R10");
    @(negedge clk); gpio_src = 1'b0;
    rd_chk(8'h2F, 8'h00, "R10");
    rd_chk(8'h2A, 8'h00, "R10");
    irq_chk(1'b0, "R10");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule